// File: doc/BRIEF.md
# Status register write unit

This block holds a processor's current status word and five saved-status copies, one for each exception mode. It carries out the move-to-status-register operation. The operand is either an 8-bit immediate rotated right by an even amount or a register value. The unit builds a byte-field write mask from the instruction, picks the target word and applies a masked update. A combinational read port returns either the current word or the saved word of the current mode, for move-from-status operations.

The unit has two variants, chosen by a parameter. The wide variant writes five flag bits and supports the compressed-instruction state bit. The narrow variant writes four flag bits and never keeps that state bit set. Whenever a write to the current word alters the mode field, a one-cycle pulse tells the register banking logic outside the block to swap register views.

Top module: `psr_write_unit`

## Requirements
- R1: After reset the current word is 0x000000D3, every saved word is 0 and `mode_changed` is low.
- R2: A write with instruction bit 22 set targets the saved word of the current mode and leaves the current word unchanged. With bit 22 clear, the current word is the target.
- R3: The current mode is current-word bits 4:0. It picks the saved word as follows: 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x14..0x17 abort, 0x18..0x1B undefined. Each bank keeps its value while other modes run.
- R4: In any other mode (for example 0x10 or 0x1F), a saved-word write changes nothing, and a saved read returns the current word.
- R5: Instruction bit 16 enables bits 7:0. Instruction bit 19 enables the flags: bits 31:27 when WIDE_FLAGS=1, bits 31:28 when WIDE_FLAGS=0. Bits 17 and 18 enable nothing. Bits outside the mask keep their old values.
- R6: In user mode (0x10), bits 7:0 of the target are never written.
- R7: Instruction bit 25 set selects the immediate operand: bits 7:0 rotated right by 2 × bits 11:8. Bit 25 clear selects `reg_val`.
- R8: Bit 4 of the operand is forced to 1 before masking.
- R9: When WIDE_FLAGS=0, bit 5 of the current word is cleared after every write to the current word.
- R10: `mode_changed` is high for exactly the one cycle after a clock edge at which a current-word write changed bits 4:0.
- R11: With `wr_en` low, no stored word changes, whatever the other inputs are.
- R12: With `rd_saved` low, `rd_data` equals the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Perform a write this cycle |
| instr | input | 32 | Instruction word |
| reg_val | input | 32 | Register operand |
| rd_saved | input | 1 | Read port selects the saved word |
| rd_data | output | 32 | Read port data |
| cur_psr | output | 32 | Current status word |
| mode_changed | output | 1 | One-cycle pulse after the mode field changes |

## Verification
The main write path is tried with two kinds of operand. Register operands tell the operand mux apart from the immediate rotator. Immediates with non-zero rotate amounts would expose a wrong rotate direction or a rotate step of one instead of two. The test visits every banked mode range, including the upper members 0x17 and 0x1B, and each time writes the saved word of the current mode and reads it back. This separates correct bank decoding from aliasing. Field patterns with only the low byte enabled, only the flags enabled, both, or only the unused bits 17 and 18 separate the two enable bits from each other. Writes made in user mode and in system mode, and the same write applied to both variants, isolate the user restriction, the unbanked fallback, the flag width and the bit-5 clear.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W     = 32;
  localparam int NUM_BANKS = 5;
  localparam logic [4:0]       MODE_USER  = 5'h10;
  localparam logic [PSR_W-1:0] PSR_RESET  = 32'h0000_00D3;

  typedef enum logic [2:0] {
    BK_FIQ = 3'd0,
    BK_IRQ = 3'd1,
    BK_SVC = 3'd2,
    BK_ABT = 3'd3,
    BK_UND = 3'd4
  } bank_e;

  typedef struct packed {
    logic  hit;
    bank_e idx;
  } bank_sel_t;

  function automatic bank_sel_t bank_lookup(input logic [4:0] mode);
    bank_sel_t r;
    r.hit = 1'b1;
    r.idx = BK_FIQ;
    casez (mode)
      5'h11:    r.idx = BK_FIQ;
      5'h12:    r.idx = BK_IRQ;
      5'h13:    r.idx = BK_SVC;
      5'b101??: r.idx = BK_ABT;
      5'b110??: r.idx = BK_UND;
      default:  r.hit = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/psr_operand.sv
module psr_operand #(
  parameter int W = 32
) (
  input  logic         use_imm,
  input  logic [3:0]   rot,
  input  logic [7:0]   imm8,
  input  logic [W-1:0] reg_val,
  output logic [W-1:0] value
);
  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] amount;
  logic [2*W-1:0]  doubled;
  logic [W-1:0]    rotated;

  always_comb begin
    amount  = SH_W'({rot, 1'b0});
    doubled = {W'(imm8), W'(imm8)} >> amount;
    rotated = doubled[W-1:0];
    value   = use_imm ? rotated : reg_val;
    value[4] = 1'b1;
  end
endmodule

// File: rtl/psr_mask.sv
module psr_mask #(
  parameter int W          = 32,
  parameter bit WIDE_FLAGS = 1'b1
) (
  input  logic         low_en,
  input  logic         flag_en,
  input  logic         user_mode,
  output logic [W-1:0] mask
);
  logic [W-1:0] flag_bits;

  generate
    if (WIDE_FLAGS) begin : g_wide
      assign flag_bits = {5'b11111, {(W-5){1'b0}}};
    end else begin : g_narrow
      assign flag_bits = {4'b1111, {(W-4){1'b0}}};
    end
  endgenerate

  always_comb begin
    mask = '0;
    if (flag_en) mask = mask | flag_bits;
    if (low_en && !user_mode) mask[7:0] = 8'hFF;
  end
endmodule

// File: rtl/psr_bank_file.sv
module psr_bank_file #(
  parameter int W         = 32,
  parameter int NUM_BANKS = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_BANKS)-1:0] sel_idx,
  input  logic [W-1:0]                 wr_data,
  output logic [W-1:0]                 sel_data
);
  localparam int IDX_W = $clog2(NUM_BANKS);

  logic [W-1:0] bank_q [NUM_BANKS];

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic         load;
      logic [W-1:0] bank_d;
      always_comb begin
        load   = wr_en && (sel_idx == IDX_W'(b));
        bank_d = load ? wr_data : bank_q[b];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q[b] <= '0;
        else        bank_q[b] <= bank_d;
      end
    end
  endgenerate

  always_comb begin
    sel_data = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_idx == IDX_W'(b)) sel_data = bank_q[b];
    end
  end
endmodule

// File: rtl/psr_write_unit.sv
module psr_write_unit
  import psr_pkg::*;
#(
  parameter bit WIDE_FLAGS = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PSR_W-1:0] instr,
  input  logic [PSR_W-1:0] reg_val,
  input  logic             rd_saved,
  output logic [PSR_W-1:0] rd_data,
  output logic [PSR_W-1:0] cur_psr,
  output logic             mode_changed
);
  localparam int IDX_W = $clog2(NUM_BANKS);

  logic [PSR_W-1:0] cur_q, cur_d;
  logic             mc_q, mc_d;
  logic [PSR_W-1:0] operand, mask, old_word, merged, bank_rd;
  logic             to_saved, cur_wr, bank_wr, user_mode;
  bank_sel_t        sel;
  logic             unused_instr_bits;

  assign unused_instr_bits = ^{instr[31:26], instr[24:23], instr[21:20],
                               instr[18:17], instr[15:12]};

  assign sel       = bank_lookup(cur_q[4:0]);
  assign user_mode = (cur_q[4:0] == MODE_USER);
  assign to_saved  = instr[22];

  psr_operand #(.W(PSR_W)) u_operand (
    .use_imm (instr[25]),
    .rot     (instr[11:8]),
    .imm8    (instr[7:0]),
    .reg_val (reg_val),
    .value   (operand)
  );

  psr_mask #(.W(PSR_W), .WIDE_FLAGS(WIDE_FLAGS)) u_mask (
    .low_en    (instr[16]),
    .flag_en   (instr[19]),
    .user_mode (user_mode),
    .mask      (mask)
  );

  always_comb begin
    cur_wr   = wr_en && !to_saved;
    bank_wr  = wr_en && to_saved && sel.hit;
    old_word = to_saved ? bank_rd : cur_q;
    merged   = (old_word & ~mask) | (operand & mask);
  end

  psr_bank_file #(.W(PSR_W), .NUM_BANKS(NUM_BANKS)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bank_wr),
    .sel_idx  (IDX_W'(sel.idx)),
    .wr_data  (merged),
    .sel_data (bank_rd)
  );

  always_comb begin
    cur_d = cur_q;
    if (cur_wr) begin
      cur_d = merged;
      if (!WIDE_FLAGS) cur_d[5] = 1'b0;
    end
    mc_d = cur_wr && (cur_d[4:0] != cur_q[4:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= PSR_RESET;
      mc_q  <= 1'b0;
    end else begin
      cur_q <= cur_d;
      mc_q  <= mc_d;
    end
  end

  assign cur_psr      = cur_q;
  assign mode_changed = mc_q;
  assign rd_data      = (rd_saved && sel.hit) ? bank_rd : cur_q;
endmodule

// File: rtl/psr_write_unit_chk.sv
module psr_write_unit_chk #(
  parameter bit WIDE_FLAGS = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] instr,
  input logic        rd_saved,
  input logic [31:0] rd_data,
  input logic [31:0] cur_psr,
  input logic        mode_changed
);
  // R5
  mid_bits_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(cur_psr[26:8]));

  // R8
  bit4_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_psr[4]);

  // R6
  user_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cur_psr[4:0] == 5'h10) |=> $stable(cur_psr[7:0]));

  // R2
  saved_keeps_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && instr[22]) |=> $stable(cur_psr));

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cur_psr));

  // R10
  mc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_changed |-> ($past(wr_en && !instr[22]) && !$stable(cur_psr[4:0])));

  // R4
  unbanked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_saved && (cur_psr[4:0] == 5'h10 || cur_psr[4:0] == 5'h1F)) |-> rd_data == cur_psr);

  generate
    if (!WIDE_FLAGS) begin : g_narrow
      // R9
      no_bit5_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_psr[5]);
    end
  endgenerate
endmodule

bind psr_write_unit psr_write_unit_chk #(.WIDE_FLAGS(WIDE_FLAGS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .instr        (instr),
  .rd_saved     (rd_saved),
  .rd_data      (rd_data),
  .cur_psr      (cur_psr),
  .mode_changed (mode_changed)
);

// File: tb/sim_psr_write_unit.sv
module sim_psr_write_unit;
  logic        clk, rst_n, wr_en, wr_en1, rd_saved;
  logic [31:0] instr, reg_val;
  logic [31:0] rd_data, cur_psr, rd_data1, cur_psr1;
  logic        mode_changed, mode_changed1;
  int          n_checks = 0, n_fail = 0;

  psr_write_unit #(.WIDE_FLAGS(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .instr(instr), .reg_val(reg_val),
    .rd_saved(rd_saved), .rd_data(rd_data), .cur_psr(cur_psr), .mode_changed(mode_changed));

  psr_write_unit #(.WIDE_FLAGS(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en1), .instr(instr), .reg_val(reg_val),
    .rd_saved(rd_saved), .rd_data(rd_data1), .cur_psr(cur_psr1), .mode_changed(mode_changed1));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        saved;
    logic        imm;
    logic [3:0]  fld;
    logic [3:0]  rot;
    logic [7:0]  imm8;
    logic [31:0] regv;
    logic [31:0] exp_cur;
    logic [31:0] exp_rd;
    logic        exp_mc;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 4'h1, 4'h0, 8'h00, 32'h0000_0011, 32'h0000_0011, 32'h0000_0000, 1'b1},
    '{1'b0, 1'b1, 4'h8, 4'h2, 8'h0F, 32'h0000_0000, 32'hF000_0011, 32'h0000_0000, 1'b0},
    '{1'b1, 1'b0, 4'h9, 4'h0, 8'h00, 32'hFFFF_FFFF, 32'hF000_0011, 32'hF800_00FF, 1'b0},
    '{1'b0, 1'b0, 4'h1, 4'h0, 8'h00, 32'h0000_0012, 32'hF000_0012, 32'h0000_0000, 1'b1},
    '{1'b1, 1'b1, 4'h1, 4'h0, 8'h05, 32'h0000_0000, 32'hF000_0012, 32'h0000_0015, 1'b0},
    '{1'b0, 1'b0, 4'h1, 4'h0, 8'h00, 32'h0000_0017, 32'hF000_0017, 32'h0000_0000, 1'b1},
    '{1'b1, 1'b1, 4'h9, 4'h4, 8'hA0, 32'h0000_0000, 32'hF000_0017, 32'hA000_0010, 1'b0},
    '{1'b0, 1'b0, 4'h1, 4'h0, 8'h00, 32'h0000_001B, 32'hF000_001B, 32'h0000_0000, 1'b1},
    '{1'b0, 1'b0, 4'h1, 4'h0, 8'h00, 32'h0000_0013, 32'hF000_0013, 32'h0000_0000, 1'b1},
    '{1'b0, 1'b0, 4'h1, 4'h0, 8'h00, 32'h0000_0033, 32'hF000_0033, 32'h0000_0000, 1'b0},
    '{1'b0, 1'b0, 4'h1, 4'h0, 8'h00, 32'h0000_001F, 32'hF000_001F, 32'hF000_001F, 1'b1},
    '{1'b1, 1'b0, 4'h1, 4'h0, 8'h00, 32'h0000_0055, 32'hF000_001F, 32'hF000_001F, 1'b0},
    '{1'b0, 1'b0, 4'h6, 4'h0, 8'h00, 32'hFFFF_FFFF, 32'hF000_001F, 32'hF000_001F, 1'b0},
    '{1'b0, 1'b0, 4'h1, 4'h0, 8'h00, 32'h0000_0000, 32'hF000_0010, 32'hF000_0010, 1'b1},
    '{1'b0, 1'b0, 4'h9, 4'h0, 8'h00, 32'h0000_0013, 32'h0000_0010, 32'h0000_0010, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(input logic saved, input logic imm,
      input logic [3:0] fld, input logic [3:0] rot, input logic [7:0] imm8);
    logic [31:0] w = '0;
    w[25] = imm; w[22] = saved; w[19:16] = fld; w[11:8] = rot; w[7:0] = imm8;
    return w;
  endfunction

  task automatic do_write(input logic [31:0] i, input logic [31:0] r, input logic on0, input logic on1);
    @(negedge clk);
    instr = i; reg_val = r; wr_en = on0; wr_en1 = on1; rd_saved = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; wr_en1 = 1'b0; rd_saved = 1'b1;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_en1 = 1'b0; rd_saved = 1'b0;
    instr = '0; reg_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_saved = 1'b1; #1;
    // R1 reset state
    check("R1 cur", cur_psr, 32'h0000_00D3);
    check("R1 mc", {31'd0, mode_changed}, 32'd0);
    check("R1 bank", rd_data, 32'h0000_0000);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int k = 0; k < NV; k++) begin
      do_write(mk_instr(TBL[k].saved, TBL[k].imm, TBL[k].fld, TBL[k].rot, TBL[k].imm8),
               TBL[k].regv, 1'b1, 1'b0);
      check("R5 cur", cur_psr, TBL[k].exp_cur);
      check("R3 rd", rd_data, TBL[k].exp_rd);
      check("R10 mc", {31'd0, mode_changed}, {31'd0, TBL[k].exp_mc});
    end

    // R11 idle: inputs move, wr_en low
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      instr = mk_instr(1'b0, 1'b0, 4'hF, 4'h0, 8'h00); reg_val = 32'hFFFF_FFFF ^ k;
      @(negedge clk);
    end
    check("R11 idle", cur_psr, 32'h0000_0010);
    // R12 read of current word
    rd_saved = 1'b0; #1;
    check("R12 cur read", rd_data, 32'h0000_0010);
    // R4 user mode saved read falls back
    rd_saved = 1'b1; #1;
    check("R4 user read", rd_data, 32'h0000_0010);

    // reset again, then the variant comparison
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    check("R1 cur after reset", cur_psr1, 32'h0000_00D3);
    do_write(mk_instr(1'b0, 1'b0, 4'h9, 4'h0, 8'h00), 32'hFFFF_FFFF, 1'b1, 1'b1);
    check("R5 wide flags", cur_psr, 32'hF800_00FF);
    check("R9 narrow clears bit5", cur_psr1, 32'hF000_00DF);
    check("R10 mc narrow", {31'd0, mode_changed1}, 32'd1);
    // R8 forced bit 4: value 0x03 becomes supervisor 0x13
    do_write(mk_instr(1'b0, 1'b0, 4'h1, 4'h0, 8'h00), 32'h0000_0003, 1'b1, 1'b0);
    check("R8 bit4", cur_psr, 32'hF800_0013);
    // R7 immediate rotate by 30: 0x81 ror 30 = 0x00000204 (low byte 0x04|0x10)
    do_write(mk_instr(1'b1, 1'b1, 4'h1, 4'hF, 8'h81), 32'h0, 1'b1, 1'b0);
    check("R7 rot30 into svc bank", rd_data, 32'h0000_0014);
    check("R2 cur unchanged", cur_psr, 32'hF800_0013);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule